// File: doc/BRIEF.md
# Queued SPI Transfer Sequencer

This block works through a list of SPI transfers held in a small internal table of entries. It needs no processor action for each word. Each entry holds a transmit word, a chip-select index, a bit count and a pause length. The host fills the table through a simple write port and chooses a window with a first and a last index. It then pulses `go`. The sequencer walks the window in order. For each entry it drives one of four active-low selects and shifts the word out in SPI mode 0 (clock idle low, sample on the rising edge). It writes the received bits back into the data field of the same entry, where the host can read them like a memory location.

With wrap enabled, the sequencer returns to the first index after the last one. A set of peripherals is then scanned for as long as needed, and each entry always holds the latest reply from its peripheral. Without wrap, the sequencer stops after the last entry and raises a sticky completion flag. A halt request stops a wrapping or linear scan cleanly, but only between entries.

The table depth must be a power of two. Index arithmetic wraps modulo the depth.

Top module: `qspi_queued_master`

## Requirements
- R1: After reset, `cs_n` is 4'b1111, `sclk` is 0, `busy` is 0 and `done` is 0, and every table field reads 0. No select goes low until an entry is launched, and all selects stay high whenever `busy` is 0.
- R2: When `go` is sampled high while idle, the sequencer latches `first_idx`, `last_idx` and `wrap_en`, clears `done` and sets `busy` on that edge. The entry's select falls one clock later, after one setup clock with all selects high.
- R3: While an entry is being shifted, exactly one select is low: `cs_n[k]` for select field value k (0..3). It does not change until the transfer ends.
- R4: Serial timing is mode 0, with HALF_CLKS = 2 system clocks per half period. The transfer sends len+1 bits, where len is the 4-bit length field. Each bit gives `sclk` low for HALF_CLKS clocks and then high for HALF_CLKS clocks. `mosi` carries data bits len down to 0, most significant first. It is valid from the select fall and changes only as `sclk` falls.
- R5: `miso` is sampled on each rising `sclk`. The len+1 received bits, right-aligned and zero-extended, replace the entry's data field when the transfer ends.
- R6: The select rises on the same clock on which `sclk` makes its final fall. It then stays high for gap+2 clocks before the next entry's select falls, where gap is the entry's 8-bit pause field.
- R7: Entries are taken from the first index upward, one by one, with the index wrapping from 15 to 0, until the last index.
- R8: Without wrap, after the pause of the last entry, `busy` falls and `done` rises. `done` stays set until the next accepted `go`.
- R9: With wrap, the entry at the first index follows the last entry, and the scan continues with no further `go`. A revisited entry transmits whatever its data field now holds, which is the reply from its previous visit.
- R10: A `halt` pulse while busy lets the current entry and its pause finish, then returns to idle with `done` left at 0. A `halt` pulse while idle has no effect on the next run.
- R11: A clock with `cfg_we` high writes `cfg_data`, `cfg_sel`, `cfg_len` and `cfg_gap` into entry `cfg_idx`. `rd_data` shows the data field of entry `rd_idx` combinationally.
- R12: `go` pulsed while busy is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_idx | input | 4 | Entry index to write |
| cfg_data | input | 16 | Transmit word |
| cfg_sel | input | 2 | Chip-select index |
| cfg_len | input | 4 | Bit count minus one |
| cfg_gap | input | 8 | Pause after the entry, in clocks |
| rd_idx | input | 4 | Entry index to read |
| rd_data | output | 16 | Data field of entry `rd_idx` |
| first_idx | input | 4 | First entry of the window |
| last_idx | input | 4 | Last entry of the window |
| wrap_en | input | 1 | Return to the first entry after the last |
| go | input | 1 | Start pulse, used only when idle |
| halt | input | 1 | Stop at the next entry boundary |
| busy | output | 1 | Sequence running |
| done | output | 1 | Sticky completion flag |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The assertions assume that `go` and `halt` are single-clock pulses and that the table is not written while a sequence runs. The assertions also assume a `halt` never arrives on the final pause clock, where it would race the boundary decision. The stimulus changes inputs just after a rising edge, writes the table only while idle, and places `halt` and the stray `go` a few clocks into a transfer. A `miso` responder built from the bench's own timing model drives the reply bits while `sclk` is low.

// File: rtl/qspi_seq_pkg.sv
package qspi_seq_pkg;

    localparam int unsigned QS_DATA_W = 16;
    localparam int unsigned QS_SEL_W  = 2;
    localparam int unsigned QS_LEN_W  = 4;
    localparam int unsigned QS_GAP_W  = 8;
    localparam int unsigned QS_CS_W   = 1 << QS_SEL_W;

    typedef struct packed {
        logic [QS_DATA_W-1:0] data;
        logic [QS_SEL_W-1:0]  sel;
        logic [QS_LEN_W-1:0]  len;
        logic [QS_GAP_W-1:0]  gap;
    } qs_entry_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEL  = 2'd1,
        SQ_XFER = 2'd2,
        SQ_GAP  = 2'd3
    } sq_state_e;

endpackage

// File: rtl/qspi_entry_store.sv
module qspi_entry_store
    import qspi_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [IDX_W-1:0]     host_idx,
    input  qs_entry_t            host_entry,
    input  logic                 wb_we,
    input  logic [IDX_W-1:0]     wb_idx,
    input  logic [QS_DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]     seq_idx,
    output qs_entry_t            seq_entry,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [QS_DATA_W-1:0] rd_data
);

    qs_entry_t tab_q [DEPTH];
    qs_entry_t tab_d [DEPTH];

    always_comb begin
        for (int i = 0; i < int'(DEPTH); i++) begin
            tab_d[i] = tab_q[i];
        end
        if (host_we) begin
            tab_d[host_idx] = host_entry;
        end
        // a reply landing on the same entry overrides the host word
        if (wb_we) begin
            tab_d[wb_idx].data = wb_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                tab_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < int'(DEPTH); i++) begin
                tab_q[i] <= tab_d[i];
            end
        end
    end

    assign seq_entry = tab_q[seq_idx];
    assign rd_data   = tab_q[rd_idx].data;

endmodule

// File: rtl/qspi_bit_engine.sv
module qspi_bit_engine
    import qspi_seq_pkg::*;
#(
    parameter int unsigned HALF_CLKS = 2,
    localparam int unsigned HC_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [QS_DATA_W-1:0] tx_word,
    input  logic [QS_LEN_W-1:0]  nbits_m1,
    input  logic                 miso,
    output logic                 sclk,
    output logic                 mosi,
    output logic                 last,
    output logic [QS_DATA_W-1:0] rx_word
);

    typedef struct packed {
        logic                 active;
        logic                 sclk;
        logic [HC_W-1:0]      hcnt;
        logic [QS_LEN_W-1:0]  bits;
        logic [QS_DATA_W-1:0] tx;
        logic [QS_DATA_W-1:0] rx;
    } eng_t;

    eng_t eng_d, eng_q;
    logic tick;

    always_comb begin
        eng_d = eng_q;
        tick  = eng_q.active && (eng_q.hcnt == '0);
        last  = tick && eng_q.sclk && (eng_q.bits == '0);
        if (start) begin
            eng_d.active = 1'b1;
            eng_d.sclk   = 1'b0;
            eng_d.hcnt   = HC_W'(HALF_CLKS - 1);
            eng_d.bits   = nbits_m1;
            eng_d.tx     = tx_word << (int'(QS_DATA_W) - 1 - int'(nbits_m1));
            eng_d.rx     = '0;
        end else if (eng_q.active) begin
            if (!tick) begin
                eng_d.hcnt = eng_q.hcnt - HC_W'(1);
            end else begin
                eng_d.hcnt = HC_W'(HALF_CLKS - 1);
                if (!eng_q.sclk) begin
                    eng_d.sclk = 1'b1;
                    eng_d.rx   = {eng_q.rx[QS_DATA_W-2:0], miso};
                end else begin
                    eng_d.sclk = 1'b0;
                    if (eng_q.bits == '0) begin
                        eng_d.active = 1'b0;
                    end else begin
                        eng_d.bits = eng_q.bits - QS_LEN_W'(1);
                        eng_d.tx   = eng_q.tx << 1;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '0;
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sclk    = eng_q.sclk;
    assign mosi    = eng_q.tx[QS_DATA_W-1];
    assign rx_word = eng_q.rx;

endmodule

// File: rtl/qspi_sequencer.sv
module qspi_sequencer
    import qspi_seq_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go,
    input  logic                 halt,
    input  logic [IDX_W-1:0]     first_idx,
    input  logic [IDX_W-1:0]     last_idx,
    input  logic                 wrap_en,
    input  qs_entry_t            entry,
    input  logic                 xfer_last,
    input  logic [QS_DATA_W-1:0] rx_word,
    output logic [IDX_W-1:0]     seq_idx,
    output logic                 start,
    output logic                 wb_we,
    output logic [IDX_W-1:0]     wb_idx,
    output logic [QS_DATA_W-1:0] wb_data,
    output logic [QS_CS_W-1:0]   cs_n,
    output logic                 busy,
    output logic                 done
);

    typedef struct packed {
        sq_state_e           st;
        logic [IDX_W-1:0]    ptr;
        logic [IDX_W-1:0]    first;
        logic [IDX_W-1:0]    last;
        logic                wrap;
        logic [QS_GAP_W-1:0] gap;
        logic                halt_pend;
        logic                done;
        logic [QS_CS_W-1:0]  cs_n;
    } seq_t;

    seq_t seq_d, seq_q;
    logic stop_now;

    always_comb begin
        seq_d    = seq_q;
        start    = 1'b0;
        wb_we    = 1'b0;
        stop_now = seq_q.halt_pend | halt;
        if (seq_q.st != SQ_IDLE) begin
            seq_d.halt_pend = stop_now;
        end
        unique case (seq_q.st)
            SQ_IDLE: begin
                if (go) begin
                    seq_d.st        = SQ_SEL;
                    seq_d.ptr       = first_idx;
                    seq_d.first     = first_idx;
                    seq_d.last      = last_idx;
                    seq_d.wrap      = wrap_en;
                    seq_d.done      = 1'b0;
                    seq_d.halt_pend = 1'b0;
                end
            end
            SQ_SEL: begin
                start      = 1'b1;
                seq_d.cs_n = ~(QS_CS_W'(1) << entry.sel);
                seq_d.gap  = entry.gap;
                seq_d.st   = SQ_XFER;
            end
            SQ_XFER: begin
                if (xfer_last) begin
                    wb_we      = 1'b1;
                    seq_d.cs_n = '1;
                    seq_d.st   = SQ_GAP;
                end
            end
            SQ_GAP: begin
                if (seq_q.gap != '0) begin
                    seq_d.gap = seq_q.gap - QS_GAP_W'(1);
                end else if (stop_now) begin
                    seq_d.st        = SQ_IDLE;
                    seq_d.halt_pend = 1'b0;
                end else if (seq_q.ptr == seq_q.last) begin
                    if (seq_q.wrap) begin
                        seq_d.ptr = seq_q.first;
                        seq_d.st  = SQ_SEL;
                    end else begin
                        seq_d.st   = SQ_IDLE;
                        seq_d.done = 1'b1;
                    end
                end else begin
                    seq_d.ptr = seq_q.ptr + IDX_W'(1);
                    seq_d.st  = SQ_SEL;
                end
            end
            default: seq_d.st = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q      <= '0;
            seq_q.st   <= SQ_IDLE;
            seq_q.cs_n <= '1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign seq_idx = seq_q.ptr;
    assign wb_idx  = seq_q.ptr;
    assign wb_data = rx_word;
    assign cs_n    = seq_q.cs_n;
    assign busy    = (seq_q.st != SQ_IDLE);
    assign done    = seq_q.done;

endmodule

// File: rtl/qspi_queued_master.sv
module qspi_queued_master
    import qspi_seq_pkg::*;
#(
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned HALF_CLKS = 2,
    localparam int unsigned IDX_W    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [IDX_W-1:0]     cfg_idx,
    input  logic [QS_DATA_W-1:0] cfg_data,
    input  logic [QS_SEL_W-1:0]  cfg_sel,
    input  logic [QS_LEN_W-1:0]  cfg_len,
    input  logic [QS_GAP_W-1:0]  cfg_gap,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [QS_DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]     first_idx,
    input  logic [IDX_W-1:0]     last_idx,
    input  logic                 wrap_en,
    input  logic                 go,
    input  logic                 halt,
    output logic                 busy,
    output logic                 done,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic [QS_CS_W-1:0]   cs_n
);

    qs_entry_t            host_entry, cur_entry;
    logic [IDX_W-1:0]     seq_idx, wb_idx;
    logic                 wb_we, start, xfer_last;
    logic [QS_DATA_W-1:0] wb_data, rx_word;

    assign host_entry = '{data: cfg_data, sel: cfg_sel, len: cfg_len, gap: cfg_gap};

    qspi_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_we    (cfg_we),
        .host_idx   (cfg_idx),
        .host_entry (host_entry),
        .wb_we      (wb_we),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .seq_idx    (seq_idx),
        .seq_entry  (cur_entry),
        .rd_idx     (rd_idx),
        .rd_data    (rd_data)
    );

    qspi_sequencer #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .halt      (halt),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .wrap_en   (wrap_en),
        .entry     (cur_entry),
        .xfer_last (xfer_last),
        .rx_word   (rx_word),
        .seq_idx   (seq_idx),
        .start     (start),
        .wb_we     (wb_we),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .cs_n      (cs_n),
        .busy      (busy),
        .done      (done)
    );

    qspi_bit_engine #(.HALF_CLKS(HALF_CLKS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tx_word  (cur_entry.data),
        .nbits_m1 (cur_entry.len),
        .miso     (miso),
        .sclk     (sclk),
        .mosi     (mosi),
        .last     (xfer_last),
        .rx_word  (rx_word)
    );

endmodule

// File: rtl/qspi_queued_master_chk.sv
module qspi_queued_master_chk
    import qspi_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               go,
    input logic               busy,
    input logic               done,
    input logic               sclk,
    input logic               mosi,
    input logic [QS_CS_W-1:0] cs_n
);

    p_idle_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&cs_n));

    p_go_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !busy) |=> busy);

    p_one_select_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    p_select_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(&cs_n) |=> ((&cs_n) || $stable(cs_n)));

    p_clk_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> !sclk);

    p_mosi_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

bind qspi_queued_master qspi_queued_master_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (go),
    .busy  (busy),
    .done  (done),
    .sclk  (sclk),
    .mosi  (mosi),
    .cs_n  (cs_n)
);

// File: tb/tb_qspi_queued_master.sv
`timescale 1ns/1ps
module tb_qspi_queued_master;

    localparam int H = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [15:0] cfg_data = '0;
    logic [1:0]  cfg_sel = '0;
    logic [3:0]  cfg_len = '0;
    logic [7:0]  cfg_gap = '0;
    logic [3:0]  rd_idx = '0;
    logic [15:0] rd_data;
    logic [3:0]  first_idx = '0;
    logic [3:0]  last_idx = '0;
    logic        wrap_en = 1'b0;
    logic        go = 1'b0;
    logic        halt = 1'b0;
    logic        busy, done, sclk, mosi;
    logic        miso = 1'b0;
    logic [3:0]  cs_n;

    always #2.5 clk = ~clk;

    qspi_queued_master #(.DEPTH(16), .HALF_CLKS(H)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .cfg_sel(cfg_sel), .cfg_len(cfg_len),
        .cfg_gap(cfg_gap), .rd_idx(rd_idx), .rd_data(rd_data),
        .first_idx(first_idx), .last_idx(last_idx), .wrap_en(wrap_en),
        .go(go), .halt(halt), .busy(busy), .done(done), .sclk(sclk),
        .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    typedef struct packed {
        logic       busy;
        logic [3:0] cs;
        logic       sclk;
        logic       mosi;
        logic       chk;
        logic       miso;
        logic [1:0] ph;
    } ev_t;

    ev_t         sched[$];
    ev_t         ev;
    int          checks = 0;
    int          errors = 0;
    bit          mon_en = 1'b0;
    logic        exp_done = 1'b0;
    int          visit_no = 0;
    logic [15:0] m_data [16];
    logic [1:0]  m_sel  [16];
    logic [3:0]  m_len  [16];
    logic [7:0]  m_gap  [16];

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the precomputed expectation
    always @(negedge clk) begin
        if (mon_en) begin
            if (sched.size() > 0) begin
                ev = sched.pop_front();
                miso = ev.miso;
                case (ev.ph)
                    2'd0:    check(cs_n == ev.cs, "R2 launch select", 32'(cs_n), 32'(ev.cs));
                    2'd1:    check(cs_n == ev.cs, "R3 R7 entry select", 32'(cs_n), 32'(ev.cs));
                    default: check(cs_n == ev.cs, "R6 pause select", 32'(cs_n), 32'(ev.cs));
                endcase
                check(sclk == ev.sclk && (!ev.chk || mosi == ev.mosi), "R4 sclk/mosi",
                      {30'd0, sclk, mosi}, {30'd0, ev.sclk, ev.mosi});
                check(busy == 1'b1 && done == 1'b0, "R8 busy/done while running",
                      {30'd0, busy, done}, 32'd2);
            end else begin
                miso = 1'b0;
                check(cs_n == 4'hF && !sclk, "R1 idle bus", {27'd0, cs_n, sclk}, 32'h1E);
                check(!busy && done == exp_done, "R8 R10 idle flags",
                      {30'd0, busy, done}, {30'd0, 1'b0, exp_done});
            end
        end
    end

    // builds the expected waveform of a run and updates the table model
    task automatic build(input int f, input int l, input bit w, input int halt_visit, output int halt_cyc);
        int   idx = f;
        ev_t  e;
        halt_cyc = -1;
        for (int v = 0; v < 64; v++) begin
            logic [15:0] resp = 16'h6B2D ^ 16'(visit_no * 16'h0F31);
            logic [15:0] tx   = m_data[idx];
            int          n    = int'(m_len[idx]);
            visit_no++;
            if (v == halt_visit) halt_cyc = sched.size() + 3;
            e = '{busy: 1'b1, cs: 4'hF, sclk: 1'b0, mosi: 1'b0, chk: 1'b0, miso: 1'b0, ph: 2'd0};
            sched.push_back(e);
            for (int b = n; b >= 0; b--) begin
                for (int c = 0; c < 2 * H; c++) begin
                    e = '{busy: 1'b1, cs: ~(4'b0001 << m_sel[idx]), sclk: (c >= H), mosi: tx[b],
                          chk: 1'b1, miso: resp[b], ph: 2'd1};
                    sched.push_back(e);
                end
            end
            for (int g = 0; g <= int'(m_gap[idx]); g++) begin
                e = '{busy: 1'b1, cs: 4'hF, sclk: 1'b0, mosi: 1'b0, chk: 1'b0, miso: 1'b0, ph: 2'd2};
                sched.push_back(e);
            end
            m_data[idx] = resp & (16'hFFFF >> (15 - n));
            if (v == halt_visit) break;
            if (idx == l) begin
                if (!w) break;
                idx = f;
            end else begin
                idx = (idx + 1) % 16;
            end
        end
    endtask

    task automatic readback(input string tag);
        for (int i = 0; i < 16; i++) begin
            rd_idx = 4'(i);
            #0.5;
            check(rd_data == m_data[i], tag, 32'(rd_data), 32'(m_data[i]));
        end
    endtask

    task automatic run(input int f, input int l, input bit w, input int halt_visit,
                       input bit go_mid, input string tag);
        int hc;
        @(posedge clk); #1;
        first_idx = 4'(f); last_idx = 4'(l); wrap_en = w; go = 1'b1;
        @(posedge clk); #1;
        go = 1'b0;
        build(f, l, w, halt_visit, hc);
        exp_done = (halt_visit < 0);
        if (halt_visit >= 0) begin
            repeat (hc) @(posedge clk);
            #1 halt = 1'b1;
            @(posedge clk); #1 halt = 1'b0;
        end
        if (go_mid) begin
            repeat (10) @(posedge clk);
            // R12: a start pulse in the middle of a transfer
            #1 go = 1'b1; first_idx = 4'd0; last_idx = 4'd15;
            @(posedge clk); #1 go = 1'b0;
        end
        wait (sched.size() == 0);
        repeat (3) @(posedge clk);
        #1;
        check(done == exp_done, tag, 32'(done), 32'(exp_done));
        readback(tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_data[i] = '0; m_sel[i] = '0; m_len[i] = '0; m_gap[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        check(cs_n == 4'hF && !sclk && !busy && !done, "R1 reset state",
              {25'd0, cs_n, sclk, busy, done}, 32'h78);
        readback("R1 R11 reset contents");
        mon_en = 1'b1;

        // fill the table while idle
        for (int i = 0; i < 16; i++) begin
            @(posedge clk); #1;
            cfg_we = 1'b1; cfg_idx = 4'(i);
            cfg_data = 16'hC3A5 ^ 16'(i * 16'h1111);
            cfg_sel = 2'(i % 4);
            cfg_len = 4'((i * 5) % 16);
            cfg_gap = 8'((i * 3) % 7);
            m_data[i] = cfg_data; m_sel[i] = cfg_sel; m_len[i] = cfg_len; m_gap[i] = cfg_gap;
        end
        @(posedge clk); #1 cfg_we = 1'b0;
        @(posedge clk); #1;
        readback("R11 host write/read");

        run(2, 5, 1'b0, -1, 1'b0, "R5 R8 linear run");
        run(14, 1, 1'b0, -1, 1'b0, "R7 index wraps 15 to 0");
        run(6, 8, 1'b1, 6, 1'b0, "R9 R10 wrap scan halted");

        // R10: a halt while idle must not affect the next run
        @(posedge clk); #1 halt = 1'b1;
        @(posedge clk); #1 halt = 1'b0;
        run(9, 9, 1'b0, -1, 1'b1, "R10 R12 single entry, idle halt, stray go");
        run(10, 13, 1'b0, 1, 1'b0, "R10 halt in linear run");
        run(3, 3, 1'b0, -1, 1'b0, "R4 R5 longest word");

        mon_en = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule